// File: doc/BRIEF.md
# Bus Adapter Interrupt Request Logic

This block decides which interrupt requests a system-bus-to-peripheral-bus adapter raises toward the processor, and which vector it returns when the processor acknowledges a level. It combines two sources. The first is the adapter's own error interrupt, held in an error-interrupt control register. The second is the set of per-level requests from ordinary devices on the peripheral bus. The two sources are evaluated independently, so a pending adapter error can never hide a device interrupt.

The control register holds a one-hot-per-level mask, a force bit, a complete bit and three enables. Two of the enables gate posted hard and soft error requests. The third gates errors generated by the adapter itself. When an adapter-initiated system-bus transaction fails, a status flag is set and the failing address is latched. Software programs and observes everything through one register write port and one combinational read port.

Top module: `adapter_irq_ctrl`

## Requirements
- R1: For every level l, `irq_o[l]` is high in any cycle where `dev_req_i[l]` is high, whatever the state of the adapter error interrupt.
- R2: The control register sits at select 0 with this layout: bits [NLEV-1:0] level mask, bit NLEV force, bit NLEV+1 complete, bit NLEV+2 hard-error enable, bit NLEV+3 soft-error enable, bit NLEV+4 adapter-error enable. `irq_o[l]` is also high whenever force is 1, complete is 0 and level bit l is 1.
- R3: An acknowledge at a level where the adapter request is active gives the following result in the cycle after the acknowledge edge: `vec_valid_o`=1, `vec_adp_o`=1, and `vec_o` equal to the adapter vector register (select 3). The same edge sets the complete bit, which withdraws the adapter request.
- R4: A hard or soft error pulse sets force and clears complete only while its own enable bit is set. Otherwise the register does not change.
- R5: An adapter-generated error pulse sets force only while the adapter-error enable is set. It leaves complete unchanged, so no request is raised while complete is 1.
- R6: A register write clears complete when the written data has complete=1 (write-1-to-clear) or force=1. Otherwise complete keeps its value.
- R7: When the adapter and a device request the same level, the first acknowledge grants the adapter. The next acknowledge grants the device: `dev_grant_o` is one-hot at that level, `vec_adp_o`=0, and `vec_o` is the device vector register for level l at select 4+l.
- R8: An acknowledge at a level with no request produces no `vec_valid_o` and no `dev_grant_o` pulse.
- R9: A transfer failure sets status bit 0 (select 1) and latches its address into the failing-address register (select 2). The register keeps the first address until software writes 1 to status bit 0. Writing 0 to that bit has no effect.
- R10: After reset, every register reads 0, `irq_o` is 0 and `vec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select for write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | SEL_W | Register select for read |
| rd_data | output | DATA_W | Read data (combinational) |
| hard_err_i | input | 1 | Posted hard error pulse |
| soft_err_i | input | 1 | Posted soft error pulse |
| adp_err_i | input | 1 | Adapter-generated error pulse |
| xfer_fail_i | input | 1 | Adapter-initiated transfer failed |
| xfer_fail_addr_i | input | ADDR_W | Address of the failed transfer |
| dev_req_i | input | NLEV | Device requests, one per level |
| irq_o | output | NLEV | Interrupt request per level |
| ack_i | input | 1 | Processor acknowledge |
| ack_lvl_i | input | LVL_W | Level being acknowledged |
| vec_valid_o | output | 1 | Vector returned this cycle |
| vec_o | output | VEC_W | Returned vector |
| vec_adp_o | output | 1 | Vector belongs to the adapter |
| dev_grant_o | output | NLEV | One-hot device grant |

## Verification
A wrong force or complete bit shows in the same cycle as a missing or stuck `irq_o` bit at the programmed level. One acknowledge later it shows as a wrong `vec_adp_o` or `vec_o`. An adapter source that masks device requests drops a device level from `irq_o` at once, and it also delays that device's grant past the second acknowledge. A failing-address register that overwrites on later failures reads back a later address on the very next read of select 2.

// File: rtl/adapter_irq_pkg.sv
package adapter_irq_pkg;
    localparam int unsigned SEL_ECR   = 0;
    localparam int unsigned SEL_STAT  = 1;
    localparam int unsigned SEL_FAR   = 2;
    localparam int unsigned SEL_AVEC  = 3;
    localparam int unsigned SEL_DVEC0 = 4;
endpackage

// File: rtl/irq_err_ctl.sv
module irq_err_ctl #(
    parameter int NLEV  = 4,
    localparam int ECR_W = NLEV + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ecr_wr,
    input  logic [ECR_W-1:0] wr_data,
    input  logic             hard_err_i,
    input  logic             soft_err_i,
    input  logic             adp_err_i,
    input  logic             adp_grant_i,
    output logic [NLEV-1:0]  lvl_o,
    output logic             adp_active_o,
    output logic [ECR_W-1:0] ecr_o
);
    localparam int B_FRC  = NLEV;
    localparam int B_DONE = NLEV + 1;
    localparam int B_HEN  = NLEV + 2;
    localparam int B_SEN  = NLEV + 3;
    localparam int B_AEN  = NLEV + 4;

    typedef struct packed {
        logic [NLEV-1:0] lvl;
        logic            frc;
        logic            done;
        logic            hen;
        logic            sen;
        logic            aen;
    } ecr_t;

    ecr_t ecr_d, ecr_q;
    logic post_w;

    assign post_w = (hard_err_i & ecr_q.hen) | (soft_err_i & ecr_q.sen);

    always_comb begin
        ecr_d = ecr_q;
        if (ecr_wr) begin
            ecr_d.lvl = wr_data[NLEV-1:0];
            ecr_d.frc = wr_data[B_FRC];
            ecr_d.hen = wr_data[B_HEN];
            ecr_d.sen = wr_data[B_SEN];
            ecr_d.aen = wr_data[B_AEN];
            if (wr_data[B_DONE] || wr_data[B_FRC]) ecr_d.done = 1'b0;
        end
        if (adp_grant_i) ecr_d.done = 1'b1;
        if (adp_err_i && ecr_q.aen) ecr_d.frc = 1'b1;
        if (post_w) begin
            ecr_d.frc  = 1'b1;
            ecr_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ecr_q <= '0;
        else        ecr_q <= ecr_d;
    end

    assign lvl_o        = ecr_q.lvl;
    assign adp_active_o = ecr_q.frc & ~ecr_q.done;

    always_comb begin
        ecr_o              = '0;
        ecr_o[NLEV-1:0]    = ecr_q.lvl;
        ecr_o[B_FRC]       = ecr_q.frc;
        ecr_o[B_DONE]      = ecr_q.done;
        ecr_o[B_HEN]       = ecr_q.hen;
        ecr_o[B_SEN]       = ecr_q.sen;
        ecr_o[B_AEN]       = ecr_q.aen;
    end

    AST_GRANT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        adp_grant_i && !post_w |=> ecr_q.done); // R3

    AST_FORCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ecr_wr && !(hard_err_i && ecr_q.hen) && !(soft_err_i && ecr_q.sen)
        && !(adp_err_i && ecr_q.aen) |=> $stable(ecr_q.frc)); // R4

    AST_SELF_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        adp_err_i && ecr_q.done && !post_w && !ecr_wr |=> ecr_q.done); // R5
endmodule

// File: rtl/irq_fail_rec.sv
module irq_fail_rec #(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_i,
    input  logic [ADDR_W-1:0] fail_addr_i,
    input  logic              clr_i,
    output logic              flag_o,
    output logic [ADDR_W-1:0] far_o
);
    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] far;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (clr_i) rec_d.flag = 1'b0;
        if (fail_i && !rec_d.flag) begin
            rec_d.flag = 1'b1;
            rec_d.far  = fail_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign flag_o = rec_q.flag;
    assign far_o  = rec_q.far;

    AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_i |=> rec_q.flag); // R9

    AST_FAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q.flag && !clr_i |=> $stable(rec_q.far)); // R9
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import adapter_irq_pkg::*;
#(
    parameter int NLEV  = 4,
    parameter int VEC_W = 9,
    parameter int SEL_W = 3,
    localparam int LVL_W = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [VEC_W-1:0]           wr_vec,
    input  logic [NLEV-1:0]            dev_req_i,
    input  logic [NLEV-1:0]            adp_lvl_i,
    input  logic                       adp_active_i,
    input  logic                       ack_i,
    input  logic [LVL_W-1:0]           ack_lvl_i,
    output logic [NLEV-1:0]            irq_o,
    output logic                       adp_grant_o,
    output logic                       vec_valid_o,
    output logic [VEC_W-1:0]           vec_o,
    output logic                       vec_adp_o,
    output logic [NLEV-1:0]            dev_grant_o,
    output logic [VEC_W-1:0]           adp_vec_o,
    output logic [NLEV-1:0][VEC_W-1:0] dev_vec_o
);
    typedef struct packed {
        logic                       vec_valid;
        logic [VEC_W-1:0]           vec;
        logic                       vec_adp;
        logic [NLEV-1:0]            dev_grant;
        logic [VEC_W-1:0]           adp_vec;
        logic [NLEV-1:0][VEC_W-1:0] dev_vec;
    } arb_t;

    arb_t arb_d, arb_q;
    logic [NLEV-1:0] adp_req;
    logic lvl_ok, adp_hit, dev_hit;

    assign adp_req = {NLEV{adp_active_i}} & adp_lvl_i;
    assign lvl_ok  = (int'(ack_lvl_i) < NLEV);
    assign adp_hit = ack_i & lvl_ok & adp_req[ack_lvl_i];
    assign dev_hit = ack_i & lvl_ok & ~adp_req[ack_lvl_i] & dev_req_i[ack_lvl_i];

    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
        assign irq_o[l] = adp_req[l] | dev_req_i[l];

        AST_DEV_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            dev_req_i[l] |-> irq_o[l]); // R1
    end

    always_comb begin
        arb_d           = arb_q;
        arb_d.vec_valid = adp_hit | dev_hit;
        arb_d.vec_adp   = adp_hit;
        arb_d.vec       = '0;
        arb_d.dev_grant = '0;
        if (adp_hit) begin
            arb_d.vec = arb_q.adp_vec;
        end else if (dev_hit) begin
            arb_d.vec                  = arb_q.dev_vec[ack_lvl_i];
            arb_d.dev_grant[ack_lvl_i] = 1'b1;
        end
        if (wr_en && wr_sel == SEL_W'(SEL_AVEC)) arb_d.adp_vec = wr_vec;
        for (int l = 0; l < NLEV; l++) begin
            if (wr_en && wr_sel == SEL_W'(SEL_DVEC0 + l)) arb_d.dev_vec[l] = wr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign adp_grant_o = adp_hit;
    assign vec_valid_o = arb_q.vec_valid;
    assign vec_o       = arb_q.vec;
    assign vec_adp_o   = arb_q.vec_adp;
    assign dev_grant_o = arb_q.dev_grant;
    assign adp_vec_o   = arb_q.adp_vec;
    assign dev_vec_o   = arb_q.dev_vec;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_q.dev_grant) && !(arb_q.vec_adp && |arb_q.dev_grant)); // R7

    AST_ADP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && lvl_ok && adp_active_i && adp_lvl_i[ack_lvl_i]
        |=> vec_adp_o && dev_grant_o == '0); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_valid_o); // R8
endmodule

// File: rtl/adapter_irq_ctrl.sv
module adapter_irq_ctrl
    import adapter_irq_pkg::*;
#(
    parameter int NLEV   = 4,
    parameter int VEC_W  = 9,
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(SEL_DVEC0 + NLEV),
    localparam int LVL_W = (NLEV > 1) ? $clog2(NLEV) : 1,
    localparam int ECR_W = NLEV + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hard_err_i,
    input  logic              soft_err_i,
    input  logic              adp_err_i,
    input  logic              xfer_fail_i,
    input  logic [ADDR_W-1:0] xfer_fail_addr_i,
    input  logic [NLEV-1:0]   dev_req_i,
    output logic [NLEV-1:0]   irq_o,
    input  logic              ack_i,
    input  logic [LVL_W-1:0]  ack_lvl_i,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_adp_o,
    output logic [NLEV-1:0]   dev_grant_o
);
    logic                       ecr_wr, stat_clr, adp_active, adp_grant, fail_flag;
    logic [NLEV-1:0]            adp_lvl;
    logic [ECR_W-1:0]           ecr;
    logic [ADDR_W-1:0]          far;
    logic [VEC_W-1:0]           adp_vec;
    logic [NLEV-1:0][VEC_W-1:0] dev_vec;

    assign ecr_wr   = wr_en && wr_sel == SEL_W'(SEL_ECR);
    assign stat_clr = wr_en && wr_sel == SEL_W'(SEL_STAT) && wr_data[0];

    irq_err_ctl #(.NLEV(NLEV)) u_err (
        .clk, .rst_n, .ecr_wr,
        .wr_data     (wr_data[ECR_W-1:0]),
        .hard_err_i, .soft_err_i, .adp_err_i,
        .adp_grant_i (adp_grant),
        .lvl_o       (adp_lvl),
        .adp_active_o(adp_active),
        .ecr_o       (ecr)
    );

    irq_fail_rec #(.ADDR_W(ADDR_W)) u_fail (
        .clk, .rst_n,
        .fail_i      (xfer_fail_i),
        .fail_addr_i (xfer_fail_addr_i),
        .clr_i       (stat_clr),
        .flag_o      (fail_flag),
        .far_o       (far)
    );

    irq_level_arb #(.NLEV(NLEV), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_arb (
        .clk, .rst_n, .wr_en, .wr_sel,
        .wr_vec      (wr_data[VEC_W-1:0]),
        .dev_req_i,
        .adp_lvl_i   (adp_lvl),
        .adp_active_i(adp_active),
        .ack_i, .ack_lvl_i, .irq_o,
        .adp_grant_o (adp_grant),
        .vec_valid_o, .vec_o, .vec_adp_o, .dev_grant_o,
        .adp_vec_o   (adp_vec),
        .dev_vec_o   (dev_vec)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_W'(SEL_ECR))       rd_data[ECR_W-1:0]  = ecr;
        else if (rd_sel == SEL_W'(SEL_STAT)) rd_data[0]          = fail_flag;
        else if (rd_sel == SEL_W'(SEL_FAR))  rd_data[ADDR_W-1:0] = far;
        else if (rd_sel == SEL_W'(SEL_AVEC)) rd_data[VEC_W-1:0]  = adp_vec;
        else begin
            for (int l = 0; l < NLEV; l++) begin
                if (rd_sel == SEL_W'(SEL_DVEC0 + l)) rd_data[VEC_W-1:0] = dev_vec[l];
            end
        end
    end
endmodule

// File: tb/adapter_irq_ctrl_test.sv
module adapter_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        hard_err_i = 1'b0, soft_err_i = 1'b0, adp_err_i = 1'b0;
    logic        xfer_fail_i = 1'b0;
    logic [29:0] xfer_fail_addr_i = '0;
    logic [3:0]  dev_req_i = '0;
    logic [3:0]  irq_o;
    logic        ack_i = 1'b0;
    logic [1:0]  ack_lvl_i = '0;
    logic        vec_valid_o;
    logic [8:0]  vec_o;
    logic        vec_adp_o;
    logic [3:0]  dev_grant_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adapter_irq_ctrl uut (
        .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
        .hard_err_i, .soft_err_i, .adp_err_i, .xfer_fail_i, .xfer_fail_addr_i,
        .dev_req_i, .irq_o, .ack_i, .ack_lvl_i, .vec_valid_o, .vec_o,
        .vec_adp_o, .dev_grant_o
    );

    // ECR fields for NLEV=4: [3:0] level, 4 force, 5 complete, 6 hard en, 7 soft en, 8 adapter en
    // table entry: {ecr write [8:0], dev_req [3:0], expected irq [3:0]}
    localparam logic [16:0] VTAB [6] = '{
        {9'h000, 4'h0, 4'h0},
        {9'h011, 4'h0, 4'h1},
        {9'h012, 4'h4, 4'h6},
        {9'h002, 4'h8, 4'h8},
        {9'h038, 4'h8, 4'h8},
        {9'h01F, 4'h0, 4'hF}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic ack(input logic [1:0] lvl);
        ack_i = 1'b1; ack_lvl_i = lvl;
        tick();
        ack_i = 1'b0;
        #1;
    endtask

    task automatic pulse_hard(); hard_err_i = 1'b1; tick(); hard_err_i = 1'b0; #1; endtask
    task automatic pulse_soft(); soft_err_i = 1'b1; tick(); soft_err_i = 1'b0; #1; endtask
    task automatic pulse_adp();  adp_err_i  = 1'b1; tick(); adp_err_i  = 1'b0; #1; endtask

    task automatic fail(input logic [29:0] a);
        xfer_fail_i = 1'b1; xfer_fail_addr_i = a;
        tick();
        xfer_fail_i = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 irq", {28'd0, irq_o}, 32'h0);
        chk("R10 vec_valid", {31'd0, vec_valid_o}, 32'h0);
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            chk("R10 reg", v, 32'h0);
        end

        // R1/R2 table walk
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, {23'd0, VTAB[i][16:8]});
            dev_req_i = VTAB[i][7:4];
            #1;
            chk("R1/R2 irq table", {28'd0, irq_o}, {28'd0, VTAB[i][3:0]});
        end
        dev_req_i = '0;

        // R3 and R7: adapter first, then device at same level
        wr(3'd3, 32'h0A5);
        wr(3'd5, 32'h0C3);
        wr(3'd0, 32'h012);
        dev_req_i = 4'b0010;
        #1;
        chk("R2 irq lvl1", {28'd0, irq_o}, 32'h2);
        ack(2'd1);
        chk("R3 vec_valid", {31'd0, vec_valid_o}, 32'h1);
        chk("R3 vec", {23'd0, vec_o}, 32'h0A5);
        chk("R7 adapter first", {31'd0, vec_adp_o}, 32'h1);
        chk("R7 no dev grant yet", {28'd0, dev_grant_o}, 32'h0);
        chk("R1 dev still requesting", {28'd0, irq_o}, 32'h2);
        rd(3'd0, v);
        chk("R3 complete set", v, 32'h032);
        ack(2'd1);
        chk("R7 dev vec", {23'd0, vec_o}, 32'h0C3);
        chk("R7 dev grant", {28'd0, dev_grant_o}, 32'h2);
        chk("R7 not adapter", {31'd0, vec_adp_o}, 32'h0);
        dev_req_i = '0;
        tick();
        chk("R7 vec pulse ends", {31'd0, vec_valid_o}, 32'h0);
        chk("R3 adapter withdrawn", {28'd0, irq_o}, 32'h0);

        // R8: empty level
        ack(2'd2);
        chk("R8 no vec", {31'd0, vec_valid_o}, 32'h0);
        chk("R8 no grant", {28'd0, dev_grant_o}, 32'h0);

        // R6: complete clearing
        wr(3'd0, 32'h022);
        rd(3'd0, v);
        chk("R6 w1c complete", v, 32'h002);
        wr(3'd0, 32'h012);
        ack(2'd1);
        rd(3'd0, v);
        chk("R6 complete again", v, 32'h032);
        wr(3'd0, 32'h012);
        rd(3'd0, v);
        chk("R6 force write clears", v, 32'h012);
        chk("R6 request back", {28'd0, irq_o}, 32'h2);

        // R4: enable gating of posted errors
        wr(3'd0, 32'h002);
        pulse_hard();
        pulse_soft();
        rd(3'd0, v);
        chk("R4 gated off", v, 32'h002);
        chk("R4 no irq", {28'd0, irq_o}, 32'h0);
        wr(3'd0, 32'h042);
        pulse_soft();
        rd(3'd0, v);
        chk("R4 soft gated", v, 32'h042);
        pulse_hard();
        rd(3'd0, v);
        chk("R4 hard posts", v, 32'h052);
        chk("R4 irq", {28'd0, irq_o}, 32'h2);
        ack(2'd1);
        rd(3'd0, v);
        chk("R4 complete", v, 32'h072);
        pulse_hard();
        rd(3'd0, v);
        chk("R4 post clears complete", v, 32'h052);
        wr(3'd0, 32'h082);
        pulse_soft();
        rd(3'd0, v);
        chk("R4 soft posts", v, 32'h092);

        // R5: adapter-generated errors
        wr(3'd0, 32'h002);
        pulse_adp();
        rd(3'd0, v);
        chk("R5 gated off", v, 32'h002);
        wr(3'd0, 32'h102);
        pulse_adp();
        rd(3'd0, v);
        chk("R5 sets force", v, 32'h112);
        ack(2'd1);
        pulse_adp();
        rd(3'd0, v);
        chk("R5 complete kept", v, 32'h132);
        chk("R5 no re-request", {28'd0, irq_o}, 32'h0);
        wr(3'd0, 32'h132);
        chk("R6/R5 re-request", {28'd0, irq_o}, 32'h2);

        // R9: failure recording
        fail(30'h1234567);
        rd(3'd1, v);
        chk("R9 flag", v, 32'h1);
        rd(3'd2, v);
        chk("R9 far", v, 32'h1234567);
        fail(30'h0ABCDEF);
        rd(3'd2, v);
        chk("R9 first kept", v, 32'h1234567);
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk("R9 write 0 ignored", v, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v);
        chk("R9 w1c", v, 32'h0);
        fail(30'h3000004);
        rd(3'd2, v);
        chk("R9 new capture", v, 32'h3000004);

        finish_run();
    end
endmodule